// File: doc/BRIEF.md
# Bus activity monitor channel

This block watches one stream of bus activity and turns it into interrupts that a frequency policy can act on. Each cycle in which `event_i` is high adds a programmable weight to a period accumulator. When the period tick arrives, the accumulated total becomes that period's sample and the accumulator starts again from zero. The sample feeds two things. The first is an exponential moving average whose window is set by an exponent field. The second is a pair of raw-count watermarks.

A raw watermark raises its status bit only after the sample has been beyond it for a programmable number of periods in a row. The average is checked against its own pair of watermarks on every period. Status bits are cleared by writing one to them. The interrupt line is the OR of the status bits whose enables are set. Software reaches all of this through a simple word-wide write port and a combinational read port.

Top module: `busmon_chan`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low. Written values read back at these word offsets: control 0x00, upper watermark 0x04, lower watermark 0x08, initial average 0x0C, average upper watermark 0x10, average lower watermark 0x14, weight 0x18. The average reads back at 0x20 and the status at 0x24.
- R2: Each clock cycle with `event_i` high adds the weight to the accumulator while the channel is enabled. A qualified tick takes the accumulator as the sample and restarts the count. An event in the tick cycle counts toward the next period.
- R3: With saturation selected (the default), the accumulator stops at the all-ones value and does not wrap.
- R4: Each qualified tick sets the average to avg + floor((sample - avg) / 2^(K+1)). K is the control field at bits 12:10.
- R5: On the rising edge of the enable bit (control bit 31), the average is loaded from the initial-average register. While the channel is disabled the accumulator is held at zero.
- R6: Control bits 28:26 hold N-1 for the upper streak. Status bit 31 is set on the N-th consecutive qualified sample that is strictly greater than the upper watermark. The streak counter then restarts from zero.
- R7: A qualified sample that is not beyond a watermark resets that watermark's streak counter to zero.
- R8: Control bits 25:23 hold M-1 for the lower streak. Status bit 30 is set on the M-th consecutive sample that is strictly below the lower watermark, and that counter then restarts.
- R9: Status bit 29 is set when the updated average is strictly above the average upper watermark. Status bit 28 is set when the updated average is strictly below the average lower watermark.
- R10: `irq_o` is high exactly when at least one status bit is set together with its enable. The pairs are status 31 with control 30, status 30 with control 29, status 29 with control 21, and status 28 with control 20.
- R11: Writing the status register clears each bit written as one and leaves the other bits unchanged. Writes never set status bits.
- R12: A tick does nothing unless control bits 31 and 18 are both set. A tick in the first cycle after enabling is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sampling period tick, one cycle wide |
| event_i | input | 1 | Activity event, one per high cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
A faulty accumulator or average register shows up in the average readback after a single tick. The bench sweeps every K value and samples on both sides of the current average, so a rounding or sign error cannot hide. A streak counter that is off by one moves the status bit and `irq_o` by exactly one period, so the bench checks every period of every streak length from 1 to 8. A mask or clear fault appears on `irq_o` or in the status readback in the very next cycle.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
   localparam int BUS_W   = 32;
   localparam int ADDR_W  = 6;
   localparam int K_W     = 3;
   localparam int NUM_W   = 3;
   localparam int NUM_VAL = 6;

   localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h00;
   localparam logic [ADDR_W-1:0] OFS_AVG    = 6'h20;
   localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h24;

   // control bit positions
   localparam int CB_EN      = 31;
   localparam int CB_PERIOD  = 18;
   localparam int CB_K_LSB   = 10;
   localparam int CB_LO_LSB  = 23;
   localparam int CB_HI_LSB  = 26;
   localparam int CB_AVLO_IE = 20;
   localparam int CB_AVHI_IE = 21;
   localparam int CB_LO_IE   = 29;
   localparam int CB_HI_IE   = 30;

   // status vector index (status bits 31..28 = index 3..0)
   localparam int ST_LSB = 28;

   typedef enum logic [2:0] {
      V_HI_WM   = 3'd0,
      V_LO_WM   = 3'd1,
      V_INIT    = 3'd2,
      V_AVHI_WM = 3'd3,
      V_AVLO_WM = 3'd4,
      V_WEIGHT  = 3'd5
   } val_idx_e;

   typedef struct packed {
      logic             en;
      logic             periodic;
      logic [K_W-1:0]   k;
      logic [NUM_W-1:0] lo_m1;
      logic [NUM_W-1:0] hi_m1;
      logic [3:0]       ie;   // {hi, lo, avg_hi, avg_lo}
   } cfg_t;

   function automatic logic [ADDR_W-1:0] val_ofs(input int idx);
      return ADDR_W'(4 * (idx + 1));
   endfunction

   function automatic cfg_t decode_ctrl(input logic [BUS_W-1:0] c);
      cfg_t r;
      r.en       = c[CB_EN];
      r.periodic = c[CB_PERIOD];
      r.k        = c[CB_K_LSB +: K_W];
      r.lo_m1    = c[CB_LO_LSB +: NUM_W];
      r.hi_m1    = c[CB_HI_LSB +: NUM_W];
      r.ie       = {c[CB_HI_IE], c[CB_LO_IE], c[CB_AVHI_IE], c[CB_AVLO_IE]};
      return r;
   endfunction
endpackage

// File: rtl/busmon_regfile.sv
module busmon_regfile
   import busmon_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   input  logic [CNT_W-1:0]  avg_i,
   input  logic [3:0]        set_i,
   output logic [BUS_W-1:0]  ctrl_o,
   output logic [CNT_W-1:0]  val_o [NUM_VAL],
   output logic [3:0]        status_o
);
   function automatic logic [BUS_W-1:0] zext(input logic [CNT_W-1:0] x);
      logic [BUS_W-1:0] r;
      r = '0;
      r[CNT_W-1:0] = x;
      return r;
   endfunction

   logic [BUS_W-1:0] ctrl_q;
   logic [3:0]       st_q;
   logic [3:0]       clr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (we_i && addr_i == OFS_CTRL) ctrl_q <= wdata_i;
   end

   for (genvar i = 0; i < NUM_VAL; i++) begin : g_val
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (we_i && addr_i == val_ofs(i)) q <= wdata_i[CNT_W-1:0];
      end
      assign val_o[i] = q;
   end

   assign clr_mask = (we_i && addr_i == OFS_STATUS) ? wdata_i[ST_LSB +: 4] : 4'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= (st_q & ~clr_mask) | set_i;
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == OFS_CTRL)   rdata_o = ctrl_q;
      if (addr_i == OFS_AVG)    rdata_o = zext(avg_i);
      if (addr_i == OFS_STATUS) rdata_o = {st_q, {ST_LSB{1'b0}}};
      for (int i = 0; i < NUM_VAL; i++)
         if (addr_i == val_ofs(i)) rdata_o = zext(val_o[i]);
   end

   assign ctrl_o   = ctrl_q;
   assign status_o = st_q;

   AST_W1C_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == 4'b0) |=> ((st_q & ~$past(st_q)) == 4'b0)); // R11
endmodule

// File: rtl/busmon_accum.sv
module busmon_accum #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             evt_i,
   input  logic [CNT_W-1:0] weight_i,
   output logic [CNT_W-1:0] acc_o
);
   logic [CNT_W-1:0] acc_q;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] add_v;

   assign sum = {1'b0, acc_q} + {1'b0, weight_i};

   if (SATURATE) begin : g_sat
      assign add_v = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         (en_i && !tick_i && evt_i) |=> (acc_q >= $past(acc_q))); // R3
   end else begin : g_wrap
      assign add_v = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (!en_i)  acc_q <= '0;
      else if (tick_i) acc_q <= evt_i ? weight_i : '0;
      else if (evt_i)  acc_q <= add_v;
   end

   assign acc_o = acc_q;

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (acc_q == '0)); // R5
endmodule

// File: rtl/busmon_ema.sv
module busmon_ema #(
   parameter int CNT_W = 32,
   parameter int K_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             upd_i,
   input  logic [K_W-1:0]   k_i,
   input  logic [CNT_W-1:0] sample_i,
   input  logic [CNT_W-1:0] init_i,
   output logic [CNT_W-1:0] avg_o,
   output logic [CNT_W-1:0] avg_next_o
);
   logic [CNT_W-1:0]        avg_q;
   logic signed [CNT_W:0]   diff;
   logic signed [CNT_W:0]   step_v;
   logic [K_W:0]            shamt;
   logic [CNT_W:0]          tmp;

   assign shamt  = {1'b0, k_i} + 1'b1;
   assign diff   = $signed({1'b0, sample_i}) - $signed({1'b0, avg_q});
   assign step_v = diff >>> shamt;
   assign tmp    = {1'b0, avg_q} + $unsigned(step_v);
   assign avg_next_o = tmp[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      avg_q <= '0;
      else if (load_i) avg_q <= init_i;
      else if (upd_i)  avg_q <= avg_next_o;
   end

   assign avg_o = avg_q;

   AST_AVG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (avg_q == $past(init_i))); // R5
   AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !upd_i) |=> $stable(avg_q)); // R12
   AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !load_i && sample_i >= avg_q) |=>
         (avg_q >= $past(avg_q) && avg_q <= $past(sample_i))); // R4
endmodule

// File: rtl/busmon_streak.sv
module busmon_streak #(
   parameter int NUM_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             step_i,
   input  logic             hit_i,
   input  logic [NUM_W-1:0] limit_m1_i,
   output logic             fire_o
);
   logic [NUM_W-1:0] cnt_q;

   assign fire_o = step_i && hit_i && (cnt_q == limit_m1_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (step_i) begin
         if (!hit_i || fire_o) cnt_q <= '0;
         else                  cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_MISS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !hit_i) |=> (cnt_q == '0)); // R7
   AST_HIT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && hit_i && !clr_i && !fire_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/busmon_chan.sv
module busmon_chan
   import busmon_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              event_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [BUS_W-1:0]  reg_wdata_i,
   output logic [BUS_W-1:0]  reg_rdata_o,
   output logic              irq_o
);
   if (CNT_W < 8 || CNT_W > BUS_W) begin : g_bad_width
      $error("busmon_chan: CNT_W must lie in 8..32");
   end

   logic [BUS_W-1:0] ctrl_w;
   logic [CNT_W-1:0] val_w [NUM_VAL];
   logic [3:0]       status_w;
   logic [3:0]       set_w;
   logic [CNT_W-1:0] acc_w, avg_w, avg_next_w;
   cfg_t             cfg;
   logic             en_q, load_w, step_w;
   logic [1:0]       hit_v, fire_v;
   logic [NUM_W-1:0] lim_v [2];

   assign cfg = decode_ctrl(ctrl_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= cfg.en;
   end

   assign load_w = cfg.en && !en_q;
   assign step_w = cfg.en && en_q && cfg.periodic && tick_i;

   busmon_regfile #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .avg_i(avg_w),
      .set_i(set_w), .ctrl_o(ctrl_w), .val_o(val_w), .status_o(status_w)
   );

   busmon_accum #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_acc (
      .clk(clk), .rst_n(rst_n), .en_i(cfg.en), .tick_i(step_w),
      .evt_i(event_i), .weight_i(val_w[V_WEIGHT]), .acc_o(acc_w)
   );

   busmon_ema #(.CNT_W(CNT_W), .K_W(K_W)) u_ema (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .upd_i(step_w),
      .k_i(cfg.k), .sample_i(acc_w), .init_i(val_w[V_INIT]),
      .avg_o(avg_w), .avg_next_o(avg_next_w)
   );

   assign hit_v[0] = acc_w > val_w[V_HI_WM];
   assign hit_v[1] = acc_w < val_w[V_LO_WM];
   assign lim_v[0] = cfg.hi_m1;
   assign lim_v[1] = cfg.lo_m1;

   for (genvar d = 0; d < 2; d++) begin : g_streak
      busmon_streak #(.NUM_W(NUM_W)) u_streak (
         .clk(clk), .rst_n(rst_n), .clr_i(!cfg.en || load_w),
         .step_i(step_w), .hit_i(hit_v[d]), .limit_m1_i(lim_v[d]),
         .fire_o(fire_v[d])
      );
   end

   assign set_w = step_w ? {fire_v[0], fire_v[1],
                            avg_next_w > val_w[V_AVHI_WM],
                            avg_next_w < val_w[V_AVLO_WM]} : 4'b0;

   assign irq_o = |(status_w & cfg.ie);

   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status_w != 4'b0)); // R10
   AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !step_w |=> ((status_w & ~$past(status_w)) == 4'b0)); // R12
   AST_SINGLE_RAW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fire_v) || (val_w[V_LO_WM] > val_w[V_HI_WM])); // R6
endmodule

// File: tb/busmon_chan_bench.sv
module busmon_chan_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0, event_i = 1'b0, reg_we_i = 1'b0;
   logic [5:0]  reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        irq_o;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   busmon_chan u_busmon_chan (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .event_i(event_i),
      .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
   );

   localparam logic [5:0] A_CTRL = 6'h00, A_HI = 6'h04, A_LO = 6'h08,
      A_INIT = 6'h0C, A_AHI = 6'h10, A_ALO = 6'h14, A_WGT = 6'h18,
      A_AVG = 6'h20, A_ST = 6'h24;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      @(negedge clk); reg_we_i = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr_i = a; #1; d = reg_rdata_o;
   endtask

   task automatic events(input int n);
      if (n > 0) begin
         @(negedge clk); event_i = 1'b1;
         repeat (n) @(negedge clk);
         event_i = 1'b0;
      end
   endtask

   task automatic tick();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask

   function automatic logic [31:0] ctl(input bit en, input bit per, input int k,
                                       input int lo_n, input int hi_n, input logic [3:0] ie);
      logic [31:0] c = '0;
      c[31] = en; c[18] = per; c[12:10] = 3'(k);
      c[25:23] = 3'(lo_n - 1); c[28:26] = 3'(hi_n - 1);
      c[30] = ie[3]; c[29] = ie[2]; c[21] = ie[1]; c[20] = ie[0];
      return c;
   endfunction

   function automatic logic [31:0] ema(input logic [31:0] a, input logic [31:0] s, input int k);
      longint d = longint'(s) - longint'(a);
      d = d >>> (k + 1);
      return 32'(longint'(a) + d);
   endfunction

   task automatic restart(input logic [31:0] c);
      wr(A_CTRL, 32'h0);
      wr(A_ST, 32'hFFFF_FFFF);
      wr(A_CTRL, c);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, expv, a, s;
      logic [31:0] pat [4];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state and readback
      for (int i = 0; i <= 9; i++) begin
         rd(6'(i * 4), r); chk("R1 reset", r, 32'h0);
      end
      chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
      for (int i = 1; i <= 6; i++) begin
         wr(6'(i * 4), 32'h1000 + 32'(i));
         rd(6'(i * 4), r); chk("R1 readback", r, 32'h1000 + 32'(i));
      end
      wr(A_CTRL, 32'h0004_2C00); rd(A_CTRL, r); chk("R1 ctrl readback", r, 32'h0004_2C00);
      wr(A_HI, 32'hFFFF_FFFF); wr(A_LO, 0); wr(A_AHI, 32'hFFFF_FFFF); wr(A_ALO, 0);
      wr(A_INIT, 0);

      // R2 accumulation sweep, K=0 so avg = sample/2
      for (int w = 1; w <= 7; w += 2)
         for (int n = 1; n <= 4; n++) begin
            wr(A_WGT, 32'(2 * w));
            restart(ctl(1, 1, 0, 1, 1, 4'b0));
            events(n); tick();
            rd(A_AVG, r); chk("R2 accumulate", r, 32'(n * w));
         end
      // R2 event on tick cycle counts toward next period
      wr(A_WGT, 32'd8);
      restart(ctl(1, 1, 0, 1, 1, 4'b0));
      @(negedge clk); tick_i = 1'b1; event_i = 1'b1;
      @(negedge clk); tick_i = 1'b0; event_i = 1'b0;
      rd(A_AVG, r); chk("R2 tick-cycle event excluded", r, 32'd0);
      tick(); rd(A_AVG, r); chk("R2 tick-cycle event next period", r, 32'd4);

      // R3 saturation
      wr(A_WGT, 32'hFFFF_FFFF);
      restart(ctl(1, 1, 0, 1, 1, 4'b0));
      events(3); tick();
      rd(A_AVG, r); chk("R3 saturate", r, 32'h7FFF_FFFF);

      // R4 / R5 EMA sweep over all K
      pat[0] = 32'd1000; pat[1] = 32'd5000; pat[2] = 32'd7; pat[3] = 32'd6;
      for (int k = 0; k < 8; k++)
         for (int p = 0; p < 4; p++) begin
            a = pat[p]; s = pat[p ^ 1];
            wr(A_INIT, a); wr(A_WGT, s);
            restart(ctl(1, 1, k, 1, 1, 4'b0));
            rd(A_AVG, r); chk("R5 init load", r, a);
            expv = a;
            for (int t = 0; t < 2; t++) begin
               events(1); tick();
               expv = ema(expv, s, k);
               rd(A_AVG, r); chk("R4 ema", r, expv);
            end
         end

      // R12 ticks ignored without periodic bit or when disabled
      wr(A_INIT, 32'd100); wr(A_WGT, 32'd900);
      restart(ctl(1, 0, 0, 1, 1, 4'b0));
      events(1); tick();
      rd(A_AVG, r); chk("R12 no periodic", r, 32'd100);
      rd(A_ST, r); chk("R12 no status without periodic", r, 32'h0);
      wr(A_CTRL, ctl(0, 1, 0, 1, 1, 4'b0));
      events(2); tick();
      rd(A_AVG, r); chk("R12 disabled", r, 32'd100);
      // R5 accumulator cleared while disabled: re-enable, tick with no events
      wr(A_CTRL, ctl(1, 1, 0, 1, 1, 4'b0)); repeat (2) @(negedge clk);
      tick(); rd(A_AVG, r); chk("R5 acc cleared", r, 32'd50);

      // R6 / R7 upper streak, all lengths
      wr(A_HI, 32'd10); wr(A_LO, 0); wr(A_WGT, 32'd20);
      wr(A_AHI, 32'hFFFF_FFFF); wr(A_ALO, 0);
      for (int n = 1; n <= 8; n++) begin
         restart(ctl(1, 1, 0, 1, n, 4'b1000));
         for (int i = 1; i <= n; i++) begin
            events(1); tick();
            rd(A_ST, r);
            chk("R6 upper streak", {31'b0, r[31]}, (i == n) ? 32'd1 : 32'd0);
            chk("R10 irq upper", {31'b0, irq_o}, (i == n) ? 32'd1 : 32'd0);
         end
         wr(A_ST, 32'h8000_0000);
         if (n > 1) begin
            for (int i = 1; i < n; i++) begin events(1); tick(); end
            tick();   // sample 0 lies inside the bounds
            for (int i = 1; i < n; i++) begin events(1); tick(); end
            rd(A_ST, r); chk("R7 upper streak broken", {31'b0, r[31]}, 32'd0);
            events(1); tick();
            rd(A_ST, r); chk("R6 upper restart", {31'b0, r[31]}, 32'd1);
         end
      end

      // R8 / R7 lower streak, length 3
      wr(A_HI, 32'hFFFF_FFFF); wr(A_LO, 32'd10);
      restart(ctl(1, 1, 0, 3, 1, 4'b0100));
      tick(); tick();
      rd(A_ST, r); chk("R8 lower not yet", {31'b0, r[30]}, 32'd0);
      events(1); tick();
      tick(); tick();
      rd(A_ST, r); chk("R7 lower streak broken", {31'b0, r[30]}, 32'd0);
      chk("R10 irq idle", {31'b0, irq_o}, 32'd0);
      tick();
      rd(A_ST, r); chk("R8 lower fires", {31'b0, r[30]}, 32'd1);
      chk("R10 irq lower", {31'b0, irq_o}, 32'd1);

      // R9 average watermarks
      wr(A_LO, 0); wr(A_INIT, 32'd100); wr(A_WGT, 32'd500);
      wr(A_AHI, 32'd200); wr(A_ALO, 32'd50);
      restart(ctl(1, 1, 0, 1, 1, 4'b0));
      events(1); tick();
      rd(A_ST, r); chk("R9 avg above", r[31:28], 4'b0010);
      wr(A_ST, 32'hFFFF_FFFF);
      tick(); rd(A_ST, r); chk("R9 avg 150 inside", r[31:28], 4'b0000);
      tick(); rd(A_ST, r); chk("R9 avg 75 inside", r[31:28], 4'b0000);
      tick(); rd(A_ST, r); chk("R9 avg below", r[31:28], 4'b0001);
      rd(A_AVG, r); chk("R4 avg 37", r, 32'd37);

      // R10 masking and R11 clear
      chk("R10 masked", {31'b0, irq_o}, 32'd0);
      wr(A_CTRL, ctl(1, 1, 0, 1, 1, 4'b0001));
      #1 chk("R10 unmasked", {31'b0, irq_o}, 32'd1);
      wr(A_AHI, 32'd20); events(1); tick();   // avg 37 -> 268: above 20
      rd(A_ST, r); chk("R11 two bits", r[31:28], 4'b0011);
      wr(A_ST, 32'h1000_0000);
      rd(A_ST, r); chk("R11 clear one", r[31:28], 4'b0010);
      chk("R10 irq after clear", {31'b0, irq_o}, 32'd0);
      wr(A_ST, 32'h0);
      rd(A_ST, r); chk("R11 zero write", r[31:28], 4'b0010);
      wr(A_ST, 32'hFFFF_FFFF);
      rd(A_ST, r); chk("R11 clear all", r, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule